// File: doc/BRIEF.md
# Two-Pass Diagonal Half-Sample Luma Interpolator

This block produces a 4x4 tile of luma samples at the diagonal half-sample position, as needed for motion-compensated prediction in a video decoder or encoder. An upstream fetch engine presents a 9x9 window of unsigned 8-bit reference pixels, one row of nine pixels per valid/ready beat. Each accepted row is filtered horizontally with a six-tap kernel into four signed intermediates. The intermediates are kept at full precision, with no rounding.

Once six intermediate rows are held, the block filters them vertically with the same kernel at 32-bit precision. It then rounds once with a combined shift of ten and clamps the result to the 0..255 range. The four output rows leave over a second valid/ready port, one row of four pixels per beat, with a last flag on the final row. Output rows are released as early as their inputs allow, so the tail of the input stream overlaps the head of the output stream. Back-pressure on the output stalls the input.

Top module: `halfpel_diag_interp`

## Requirements
- R1: The horizontal pass gives result column k of an input row as (p[k]+p[k+5]) + 20*(p[k+2]+p[k+3]) - 5*(p[k+1]+p[k+4]), for k = 0..3. Pixel j of `in_row` sits in bits [8j+7:8j].
- R2: Horizontal results are stored as signed 16-bit values, with no rounding and no shift before the vertical pass.
- R3: Output row r, column k, uses the intermediates of rows r..r+5 in that column. Rows r and r+5 carry weight 1, rows r+2 and r+3 carry weight 20, and rows r+1 and r+4 carry weight -5. The sum is formed at 32-bit signed precision.
- R4: The vertical sum is rounded as (sum + 512) >> 10, using an arithmetic shift.
- R5: A negative rounded value gives 0 and a value above 255 gives 255. Output column k sits in `out_row` bits [8k+7:8k].
- R6: Exactly 9 input beats are accepted per tile. After the ninth beat, `in_ready` stays low until the tile's last output row is accepted.
- R7: Four output beats carry rows 0, 1, 2, 3 in order. `out_last` is high on row 3 only.
- R8: Output row r is valid from the cycle after input row r+5 is accepted, and not before.
- R9: While `out_valid` is high and `out_ready` is low, `out_row` and `out_last` hold steady and `in_ready` is low.
- R10: A synchronous active-low reset clears the row counters. After reset, `out_valid` is low and `in_ready` is high, and a new tile starts with row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input row present |
| in_ready | output | 1 | Input row accepted this cycle when high together with in_valid |
| in_row | input | 72 | Nine reference pixels, pixel 0 in the low byte |
| out_valid | output | 1 | Output row present |
| out_ready | input | 1 | Downstream takes the output row |
| out_row | output | 32 | Four interpolated pixels, column 0 in the low byte |
| out_last | output | 1 | High on the fourth output row of a tile |

## Verification
The two functions that can fall in the same cycle are taking in input rows 6..8 and emitting output rows 0..2. With both ports kept ready and no gaps, each of the three late input beats shares its edge with an output beat. The bench provokes this overlap and also a staggered variant with output back-pressure and input gaps. In every sampled cycle it checks `out_valid` against the rule that row r needs r+6 accepted input rows, and it compares every emitted row with an integer reference model. A correct overlap therefore shows up both in the cycle timing and in the data, since a row written late or read early would corrupt the sums.

// File: rtl/halfpel_diag_interp.sv
module halfpel_diag_interp #(
  parameter int PIX_W = 8,
  parameter int WIN   = 9,
  parameter int TILE  = 4,
  parameter int MID_W = 16,
  parameter int ACC_W = 32,
  parameter int SHIFT = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [WIN*PIX_W-1:0]  in_row,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [TILE*PIX_W-1:0] out_row,
  output logic                  out_last
);
  localparam int TAPS  = WIN - TILE + 1;
  localparam int ROW_W = $clog2(WIN + 1);
  localparam int OUT_W = (TILE > 1) ? $clog2(TILE) : 1;

  function automatic logic signed [MID_W-1:0] hfilt(
    input logic signed [MID_W-1:0] a, b, c, d, e, f);
    return (a + f) + (c + d) * $signed(MID_W'(20)) - (b + e) * $signed(MID_W'(5));
  endfunction

  function automatic logic signed [ACC_W-1:0] vfilt(
    input logic signed [ACC_W-1:0] a, b, c, d, e, f);
    return (a + f) + (c + d) * $signed(ACC_W'(20)) - (b + e) * $signed(ACC_W'(5));
  endfunction

  logic signed [MID_W-1:0] mid [WIN][TILE];
  logic signed [MID_W-1:0] hres [TILE];
  logic [ROW_W-1:0] rows_in;
  logic [OUT_W-1:0] row_out;

  wire in_fire  = in_valid && in_ready;
  wire out_fire = out_valid && out_ready;

  assign out_valid = rows_in >= ROW_W'(TAPS) + ROW_W'(row_out);
  assign out_last  = out_valid && (row_out == OUT_W'(TILE - 1));
  assign in_ready  = (rows_in < ROW_W'(WIN)) && !(out_valid && !out_ready);

  for (genvar k = 0; k < TILE; k++) begin : g_h
    logic signed [MID_W-1:0] p [TAPS];
    for (genvar j = 0; j < TAPS; j++) begin : g_tap
      assign p[j] = $signed({{(MID_W-PIX_W){1'b0}}, in_row[(k+j)*PIX_W +: PIX_W]});
    end
    assign hres[k] = hfilt(p[0], p[1], p[2], p[3], p[4], p[5]);
  end

  for (genvar k = 0; k < TILE; k++) begin : g_v
    logic signed [ACC_W-1:0] t [TAPS];
    logic signed [ACC_W-1:0] vsum, rnd, shr;
    for (genvar j = 0; j < TAPS; j++) begin : g_tap
      logic signed [MID_W-1:0] m;
      assign m    = mid[ROW_W'(row_out) + ROW_W'(j)][k];
      assign t[j] = {{(ACC_W-MID_W){m[MID_W-1]}}, m};
    end
    assign vsum = vfilt(t[0], t[1], t[2], t[3], t[4], t[5]);
    assign rnd  = vsum + $signed(ACC_W'(1) << (SHIFT - 1));
    assign shr  = rnd >>> SHIFT;
    always_comb begin
      if (shr < 0)
        out_row[k*PIX_W +: PIX_W] = '0;
      else if (shr > $signed({{(ACC_W-PIX_W){1'b0}}, {PIX_W{1'b1}}}))
        out_row[k*PIX_W +: PIX_W] = '1;
      else
        out_row[k*PIX_W +: PIX_W] = shr[PIX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire)
      for (int k = 0; k < TILE; k++) mid[rows_in][k] <= hres[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rows_in <= '0;
      row_out <= '0;
    end else begin
      if (in_fire) rows_in <= rows_in + 1'b1;
      if (out_fire) begin
        if (out_last) begin
          rows_in <= '0;
          row_out <= '0;
        end else begin
          row_out <= row_out + 1'b1;
        end
      end
    end
  end
endmodule

module halfpel_diag_interp_chk #(
  parameter int PIX_W = 8,
  parameter int WIN   = 9,
  parameter int TILE  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic                  out_last,
  input logic [TILE*PIX_W-1:0] out_row
);
  logic [7:0] c_in, c_out;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_in  <= '0;
      c_out <= '0;
    end else begin
      if (in_valid && in_ready) c_in <= c_in + 1'b1;
      if (out_valid && out_ready) begin
        if (out_last) begin
          c_in  <= '0;
          c_out <= '0;
        end else begin
          c_out <= c_out + 1'b1;
        end
      end
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_row) && $stable(out_last));
  a_r9_stall_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  a_r7_last_row: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (c_out == 8'(TILE - 1))));
  a_r8_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> c_in >= c_out + 8'(WIN - TILE + 1));
  a_r6_nine: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> c_in < 8'(WIN));
  a_r10_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid && in_ready);
endmodule

bind halfpel_diag_interp halfpel_diag_interp_chk #(.PIX_W(PIX_W), .WIN(WIN), .TILE(TILE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last), .out_row(out_row));

// File: tb/halfpel_diag_interp_tb.sv
module halfpel_diag_interp_tb;
  logic clk = 0, rst_n = 0, in_valid = 0, out_ready = 0;
  logic [71:0] in_row = '0;
  logic in_ready, out_valid, out_last;
  logic [31:0] out_row;
  int checks = 0, fails = 0, cyc = 0, in_acc = 0;
  int win [9][9];

  always #5 clk = ~clk;

  halfpel_diag_interp u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_row(in_row), .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row), .out_last(out_last));

  // mode, seed, stall
  localparam int TBL [9][3] = '{
    '{0, 0, 0}, '{1, 0, 1}, '{2, 0, 0}, '{3, 11, 1}, '{4, 0, 0},
    '{5, 0, 1}, '{6, 0, 0}, '{3, 77, 0}, '{7, 5, 1}};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pix(int mode, int seed, int r, int c);
    case (mode)
      0: return 0;
      1: return 255;
      2: return ((r + c) % 2) ? 255 : 0;
      3: return (seed * 37 + r * 101 + c * 53 + r * c * 17 + (r ^ c) * 29) % 256;
      4: return (c * 28 + r * 3) % 256;
      5: return (c % 3 == 1) ? 255 : 0;
      6: return (r % 3 == 1) ? 255 : 0;
      default: return ((r % 2) ^ (c % 2)) ? 0 : 255 - seed;
    endcase
  endfunction

  function automatic int hval(int r, int k);
    return win[r][k] + win[r][k+5] + 20 * (win[r][k+2] + win[r][k+3]) - 5 * (win[r][k+1] + win[r][k+4]);
  endfunction

  function automatic int ref_pix(int r, int k);
    int s;
    s = hval(r, k) + hval(r+5, k) + 20 * (hval(r+2, k) + hval(r+3, k)) - 5 * (hval(r+1, k) + hval(r+4, k));
    s = (s + 512) >>> 10;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  function automatic logic [31:0] ref_row(int r);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) v[k*8 +: 8] = 8'(ref_pix(r, k));
    return v;
  endfunction

  task automatic drive(input int nrows, input bit gaps);
    for (int r = 0; r < nrows; r++) begin
      @(negedge clk);
      in_valid = 1;
      for (int c = 0; c < 9; c++) in_row[c*8 +: 8] = 8'(win[r][c]);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      in_acc++;
      if (gaps && (r % 2 == 1)) begin @(negedge clk); in_valid = 0; end
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic receive(input bit stall);
    int got = 0, sc = 0;
    bit held = 0;
    logic [31:0] hdat;
    while (got < 4) begin
      @(negedge clk);
      out_ready = stall ? (sc % 3 == 2) : 1'b1;
      sc++;
      #1;
      chk(out_valid == (in_acc >= got + 6), "R8 row release", out_valid, in_acc >= got + 6);
      if (in_acc == 9) chk(!in_ready, "R6 no tenth beat", in_ready, 0);
      if (held) chk(out_valid && out_row == hdat, "R9 hold", out_row, hdat);
      held = 0;
      if (out_valid && !out_ready) begin
        chk(!in_ready, "R9 input stall", in_ready, 0);
        held = 1;
        hdat = out_row;
      end
      if (out_valid && out_ready) begin
        chk(out_row == ref_row(got), "R1 R2 R3 R4 R5 data", out_row, ref_row(got));
        chk(out_last == (got == 3), "R7 last flag", out_last, got == 3);
        got++;
      end
    end
    @(negedge clk);
    out_ready = 0;
    in_acc = 0;
  endtask

  task automatic load(input int mode, input int seed);
    for (int r = 0; r < 9; r++)
      for (int c = 0; c < 9; c++) win[r][c] = pix(mode, seed, r, c);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!out_valid && in_ready, "R10 reset state", {out_valid, in_ready}, 2'b01);

    foreach (TBL[i]) begin
      load(TBL[i][0], TBL[i][1]);
      fork
        drive(9, TBL[i][2] != 0);
        receive(TBL[i][2] != 0);
      join
    end

    // R10: reset in the middle of a tile, with an output row pending
    load(3, 200);
    drive(6, 0);
    #1;
    chk(out_valid, "R8 pending before reset", out_valid, 1);
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(!out_valid && in_ready, "R10 mid-tile reset", {out_valid, in_ready}, 2'b01);
    in_acc = 0;
    load(4, 0);
    fork
      drive(9, 0);
      receive(0);
    join

    // R5: extreme saturating windows once more after the others
    load(1, 0);
    fork drive(9, 1); receive(0); join
    load(0, 0);
    fork drive(9, 0); receive(1); join

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule